// File: doc/BRIEF.md
# I2C Register-Pair Target for a 16-bit Port

This block is an I2C-bus target that fronts a 16-bit general-purpose port. It watches oversampled SCL and SDA lines and finds START, repeated START and STOP conditions. It accepts a 7-bit device address whose upper four bits are fixed at 0100 and whose lower three bits come from strap pins. It then takes a command byte that points at one of eight byte-wide registers, and either accepts data bytes into that register or returns its contents.

The eight registers form four 16-bit pairs:
- the live input port,
- the output values,
- the polarity inversion mask,
- the pin direction configuration.

After every data byte, whether read or written, the pointer moves to the other byte of the same pair, so a long transfer alternates between the low and high halves instead of walking through the map. The written pairs are presented as outputs for the surrounding port logic. The block answers on the bus only through an open-drain pull-low output.

Top module: `i2c_pair_target`

## Requirements
- R1: The block acknowledges (pulls SDA low during the ninth clock) an address byte whose upper seven bits equal {4'b0100, addr_pins}. The LSB of that byte is the direction: 0 means write, 1 means read.
- R2: After an address that does not match, the block keeps SDA released and changes no register until the next START.
- R3: After a write-direction address, the block acknowledges the next byte as a command. Bits [2:0] of the command select the register: 0/1 input low/high, 2/3 output low/high, 4/5 polarity low/high, 6/7 configuration low/high. Bit 0 selects the low or high byte of the pair.
- R4: After a repeated START and a read-direction address, the first byte returned is the register selected by the command. Each later byte comes from the other byte of the same pair, alternating.
- R5: A read goes on for as many bytes as the master acknowledges. After the master answers a byte with NACK, SDA stays released until the next START.
- R6: In a write transfer, each data byte is acknowledged and stored into the selected register, and the pointer then moves to the other byte of the pair.
- R7: Writes aimed at the input registers (command 0 or 1) are acknowledged but change no stored register.
- R8: After reset, SDA is released, output and configuration read all ones, and polarity reads all zeros.
- R9: A STOP at any point ends the transfer. Clock pulses that follow without a START get no acknowledge and cause no write.
- R10: The input port is sampled into the transmit shifter on the falling SCL edge that ends the preceding acknowledge bit. Input changes after that edge appear only in later bytes.
- R11: Bytes move MSB first in both directions, and the block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_pins | input | 3 | Strap value for the low three address bits |
| port_in | input | 16 | Live input port levels |
| out_reg | output | 16 | Output value pair {high, low} |
| pol_reg | output | 16 | Polarity inversion pair {high, low} |
| cfg_reg | output | 16 | Direction configuration pair {high, low} |

## Verification
The hardest case to reach is the moment the input port is sampled during a read. The port must change inside the narrow window between the acknowledge falling edge and the next sampling edge. The bench reaches it by changing port_in just after the read address has been acknowledged. It then expects the old value in the first byte and the new value in the mate byte. The alternating pointer is checked with long directed reads and with seeded random write/read mixes that start on either member of any pair. The other cases are reached with directed sequences: NACK-then-clocking, STOP-then-clocking and mismatched addresses.

// File: rtl/i2c_pair_pkg.sv
package i2c_pair_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 3;
  localparam logic [3:0] DEV_HI = 4'b0100;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_TX, ST_MACK, ST_IGNORE
  } st_t;

  function automatic logic addr_hit(input logic [6:0] a, input logic [2:0] pins);
    return a == {DEV_HI, pins};
  endfunction

  function automatic logic [IDX_W-1:0] pair_mate(input logic [IDX_W-1:0] p);
    return {p[IDX_W-1:1], ~p[0]};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [2*BYTE_W-1:0] w, input logic hi);
    return hi ? w[2*BYTE_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int NSYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [NSYNC-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[NSYNC-2:0], scl_i};
      sda_q <= {sda_q[NSYNC-2:0], sda_i};
      scl_d <= scl_q[NSYNC-1];
      sda_d <= sda_q[NSYNC-1];
    end
  end

  assign scl_s     = scl_q[NSYNC-1];
  assign sda_s     = sda_q[NSYNC-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges while the clock stays high mark bus conditions
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_pair_regbank.sv
module i2c_pair_regbank
  import i2c_pair_pkg::*;
#(
  parameter logic [2*BYTE_W-1:0] OUT_RST = '1,
  parameter logic [2*BYTE_W-1:0] POL_RST = '0,
  parameter logic [2*BYTE_W-1:0] CFG_RST = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      widx,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic [IDX_W-1:0]      ridx,
  input  logic [2*BYTE_W-1:0]   port_in,
  output logic [BYTE_W-1:0]     rdata,
  output logic [2*BYTE_W-1:0]   out_q,
  output logic [2*BYTE_W-1:0]   pol_q,
  output logic [2*BYTE_W-1:0]   cfg_q
);
  localparam int NPAIR = 1 << (IDX_W - 1);
  logic [2*BYTE_W-1:0] bank [NPAIR];

  assign bank[0] = port_in;

  for (genvar g = 1; g < NPAIR; g++) begin : g_pair
    localparam logic [2*BYTE_W-1:0] RV = (g == 1) ? OUT_RST : (g == 2) ? POL_RST : CFG_RST;
    logic [2*BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RV;
      else if (wr_en && widx[IDX_W-1:1] == (IDX_W-1)'(g)) begin
        if (widx[0]) q[2*BYTE_W-1:BYTE_W] <= wdata;
        else         q[BYTE_W-1:0]        <= wdata;
      end
    end
    assign bank[g] = q;
  end

  assign rdata = pick_byte(bank[ridx[IDX_W-1:1]], ridx[0]);
  assign out_q = bank[1];
  assign pol_q = bank[2];
  assign cfg_q = bank[3];
endmodule

// File: rtl/i2c_pair_engine.sv
module i2c_pair_engine
  import i2c_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        addr_pins,
  input  logic [BYTE_W-1:0] rdata,
  output logic              sda_low,
  output logic [IDX_W-1:0]  ptr,
  output logic [IDX_W-1:0]  ridx,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wdata,
  output st_t               st
);
  logic [BYTE_W-1:0] sh;
  logic [2:0]        cnt;
  logic              got8, rw, mnack;

  // the mate is fetched while waiting on the master's acknowledge
  assign ridx = (st == ST_MACK) ? pair_mate(ptr) : ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sh <= '0; cnt <= '0; got8 <= 1'b0; rw <= 1'b0;
      mnack <= 1'b0; sda_low <= 1'b0; ptr <= '0; wr_en <= 1'b0; wdata <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st <= ST_ADDR; cnt <= '0; got8 <= 1'b0; sda_low <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; got8 <= 1'b0; sda_low <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) got8 <= 1'b1;
            end else if (scl_fall && got8) begin
              got8 <= 1'b0;
              if (st == ST_ADDR) begin
                if (addr_hit(sh[7:1], addr_pins)) begin
                  rw <= sh[0]; sda_low <= 1'b1; st <= ST_ADDR_ACK;
                end else st <= ST_IGNORE;
              end else if (st == ST_CMD) begin
                ptr <= sh[IDX_W-1:0]; sda_low <= 1'b1; st <= ST_CMD_ACK;
              end else begin
                wr_en <= 1'b1; wdata <= sh; sda_low <= 1'b1; st <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              sh <= rdata; sda_low <= ~rdata[BYTE_W-1]; st <= ST_TX;
            end else begin
              sda_low <= 1'b0; st <= ST_CMD;
            end
          end
          ST_CMD_ACK: if (scl_fall) begin
            sda_low <= 1'b0; cnt <= '0; st <= ST_WDATA;
          end
          ST_WDATA_ACK: if (scl_fall) begin
            sda_low <= 1'b0; cnt <= '0; ptr <= pair_mate(ptr); st <= ST_WDATA;
          end
          ST_TX: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_low <= 1'b0; st <= ST_MACK;
            end else begin
              cnt <= cnt + 3'd1;
              sh <= {sh[BYTE_W-2:0], 1'b0};
              sda_low <= ~sh[BYTE_W-2];
            end
          end
          ST_MACK: begin
            if (scl_rise) mnack <= sda_s;
            else if (scl_fall) begin
              if (mnack) st <= ST_IGNORE;
              else begin
                ptr <= pair_mate(ptr); sh <= rdata; cnt <= '0;
                sda_low <= ~rdata[BYTE_W-1]; st <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_pair_target.sv
module i2c_pair_target
  import i2c_pair_pkg::*;
#(
  parameter int NSYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_drive_low,
  input  logic [2:0]  addr_pins,
  input  logic [15:0] port_in,
  output logic [15:0] out_reg,
  output logic [15:0] pol_reg,
  output logic [15:0] cfg_reg
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IDX_W-1:0] ptr, ridx;
  logic [BYTE_W-1:0] wdata, rdata;
  st_t st;

  i2c_line_sync #(.NSYNC(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_pair_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_pins(addr_pins), .rdata(rdata), .sda_low(sda_drive_low),
    .ptr(ptr), .ridx(ridx), .wr_en(wr_en), .wdata(wdata), .st(st)
  );

  i2c_pair_regbank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .widx(ptr), .wdata(wdata),
    .ridx(ridx), .port_in(port_in), .rdata(rdata),
    .out_q(out_reg), .pol_q(pol_reg), .cfg_q(cfg_reg)
  );
endmodule

// File: rtl/i2c_pair_target_chk.sv
module i2c_pair_target_chk
  import i2c_pair_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        start_det,
  input logic        stop_det,
  input logic        drv,
  input logic        wr_en,
  input logic [2:0]  widx,
  input st_t         st,
  input logic [47:0] regs
);
  // R11
  drv_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv) |-> (!scl_s || $past(start_det || stop_det)));
  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> !drv);
  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE && !drv));
  // R7
  input_wr_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx[2:1] == 2'd0) |=> $stable(regs));
  // R6
  write_only_in_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (st == ST_WDATA_ACK));
  // R1
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR && !drv));
endmodule

bind i2c_pair_target i2c_pair_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .drv(sda_drive_low), .wr_en(wr_en), .widx(ptr),
  .st(st), .regs({out_reg, pol_reg, cfg_reg})
);

// File: tb/sim_i2c_pair_target.sv
module sim_i2c_pair_target;
  localparam int H = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] pins = 3'b101;
  logic [15:0] port_in = 16'hA55A;
  logic sda_drive_low;
  logic [15:0] out_reg, pol_reg, cfg_reg;
  logic sda_line;
  int n_chk = 0, n_bad = 0;
  logic [15:0] m_out = 16'hFFFF, m_pol = 16'h0000, m_cfg = 16'hFFFF;

  always #2 clk = ~clk;
  assign sda_line = m_sda & ~sda_drive_low;

  i2c_pair_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_drive_low(sda_drive_low), .addr_pins(pins), .port_in(port_in),
    .out_reg(out_reg), .pol_reg(pol_reg), .cfg_reg(cfg_reg)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic wbit(input logic b);
    m_scl = 1'b0; wt(H/2); m_sda = b; wt(H/2);
    m_scl = 1'b1; wt(H); m_scl = 1'b0;
  endtask

  task automatic rbit(output logic b);
    m_scl = 1'b0; wt(H/2); m_sda = 1'b1; wt(H/2);
    m_scl = 1'b1; wt(H/2); b = sda_line; wt(H/2); m_scl = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack_low);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(v[i]);  // R11 MSB first
    rbit(a);
    ack_low = ~a;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(give_ack ? 1'b0 : 1'b1);
  endtask

  task automatic bstart;  // works as START and repeated START
    m_scl = 1'b0; wt(H/2); m_sda = 1'b1; wt(H/2);
    m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b0;
  endtask

  task automatic bstop;
    m_scl = 1'b0; wt(H/2); m_sda = 1'b0; wt(H/2);
    m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
  endtask

  function automatic logic [7:0] mread(input logic [2:0] idx);
    logic [15:0] w;
    case (idx[2:1])
      2'd0: w = port_in;
      2'd1: w = m_out;
      2'd2: w = m_pol;
      default: w = m_cfg;
    endcase
    return idx[0] ? w[15:8] : w[7:0];
  endfunction

  function automatic void mwrite(input logic [2:0] idx, input logic [7:0] v);
    case (idx[2:1])
      2'd1: if (idx[0]) m_out[15:8] = v; else m_out[7:0] = v;
      2'd2: if (idx[0]) m_pol[15:8] = v; else m_pol[7:0] = v;
      2'd3: if (idx[0]) m_cfg[15:8] = v; else m_cfg[7:0] = v;
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] aw(input logic rd);
    return {4'b0100, pins, rd};
  endfunction

  task automatic check_regs(input string tag);
    chk(tag, out_reg, m_out);
    chk(tag, pol_reg, m_pol);
    chk(tag, cfg_reg, m_cfg);
  endtask

  // write n bytes starting at idx, checking acks
  task automatic do_write(input logic [2:0] idx, input int n, input logic [7:0] d0, input string tag);
    logic a;
    logic [2:0] p = idx;
    logic [7:0] v = d0;
    bstart; wbyte(aw(1'b0), a); chk("R1 addr ack", 16'(a), 16'd1);
    wbyte({5'd0, idx}, a); chk("R3 cmd ack", 16'(a), 16'd1);
    for (int i = 0; i < n; i++) begin
      wbyte(v, a); chk({tag, " data ack"}, 16'(a), 16'd1);
      mwrite(p, v); p[0] = ~p[0]; v = v * 8'd37 + 8'd11;
    end
    bstop; wt(4);
  endtask

  task automatic do_read(input logic [2:0] idx, input int n, input string tag);
    logic a;
    logic [7:0] v;
    logic [2:0] p = idx;
    bstart; wbyte(aw(1'b0), a); wbyte({5'd0, idx}, a);
    bstart; wbyte(aw(1'b1), a); chk("R1 read addr ack", 16'(a), 16'd1);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, v);
      chk(tag, 16'(v), 16'(mread(p)));
      p[0] = ~p[0];
    end
    bstop; wt(4);
  endtask

  initial begin
    logic a;
    logic [7:0] v;
    logic [15:0] snap;
    void'($urandom(32'h5EED));
    wt(5); rst_n = 1'b1; wt(3);
    chk("R8 sda released", 16'(sda_drive_low), 16'd0);
    check_regs("R8 reset values");

    do_write(3'd2, 3, 8'h12, "R6");
    check_regs("R6 pair alternation write");
    do_write(3'd7, 2, 8'h3C, "R6");
    check_regs("R6 cfg write from high byte");

    do_read(3'd1, 5, "R4 alternating read from in1");
    do_read(3'd2, 4, "R4 R5 long read of out pair");
    do_read(3'd6, 1, "R4 single byte cfg0");

    // R10: input changes right after the read address is acknowledged
    bstart; wbyte(aw(1'b0), a); wbyte(8'd0, a);
    bstart; wbyte(aw(1'b1), a);
    wt(H/2); port_in = 16'h3CC3;
    rbyte(1'b1, v); chk("R10 first byte holds old input", 16'(v), 16'h005A);
    rbyte(1'b0, v); chk("R10 mate byte shows new input", 16'(v), 16'h003C);
    bstop; wt(4);

    // R5: after NACK, further clocks see a released line
    bstart; wbyte(aw(1'b0), a); wbyte(8'd6, a);
    bstart; wbyte(aw(1'b1), a);
    rbyte(1'b0, v); chk("R5 byte before nack", 16'(v), 16'(mread(3'd6)));
    rbyte(1'b0, v); chk("R5 released after nack", 16'(v), 16'h00FF);
    bstop; wt(4);

    // R2: wrong strap address
    pins = 3'b010;
    bstart; wbyte({4'b0100, 3'b101, 1'b0}, a); chk("R2 mismatch no ack", 16'(a), 16'd0);
    wbyte(8'd2, a); chk("R2 cmd no ack", 16'(a), 16'd0);
    wbyte(8'h99, a); chk("R2 data no ack", 16'(a), 16'd0);
    bstop; wt(4);
    check_regs("R2 registers untouched");

    // R7: input registers ignore writes
    snap = port_in;
    do_write(3'd0, 2, 8'h00, "R7");
    check_regs("R7 input write ignored");
    do_read(3'd0, 2, "R7 input still live");
    chk("R7 port unchanged", port_in, snap);

    // R9: STOP ends it, later clocking is ignored
    bstart; wbyte(aw(1'b0), a); wbyte(8'd4, a); bstop; wt(4);
    wbyte(8'h77, a); chk("R9 no ack after stop", 16'(a), 16'd0);
    wt(4);
    check_regs("R9 no write after stop");

    // random mix
    for (int it = 0; it < 30; it++) begin
      logic [2:0] widx, ridx;
      widx = 3'($urandom_range(2, 7));
      ridx = 3'($urandom_range(0, 7));
      port_in = 16'($urandom);
      do_write(widx, int'($urandom_range(1, 4)), 8'($urandom), "R6 random");
      check_regs("R6 random regs");
      do_read(ridx, int'($urandom_range(1, 4)), "R4 random read");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired got=hang exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule